// File: doc/BRIEF.md
# Locked Configuration Index Port

This block sits behind two adjacent I/O addresses and gives a host access to a byte-wide configuration space. The lower address is the index port and the higher one is the data port. After reset the space is closed. The host opens it by writing a key byte twice in a row to the index port, and closes it again by writing a lock byte there. While the space is open, a write to the index port selects a register, and a write or read of the data port then reaches that register.

Index 0x07 holds the logical device number. Indices from 0x30 upward belong to the bank of the selected device. Inside a bank, 0x30 is the enable byte, 0x60 and 0x61 are the high and low bytes of the I/O base, 0x70 is the interrupt number, and 0x71 is the interrupt type, where 1 means active-low level. Those banks are outside this block. It drives a one-hot write strobe, the index and the write byte towards them, and returns the selected bank's read byte. Three scratch bytes sit at 0x28, 0x29 and 0x2D. They are shared by all devices and do not depend on the device number.

Top module: `cfgp_index_port`

## Requirements
- R1: After reset the space is closed (`cfg_open` = 0), `dev_wr` is 0, and reads of either port return 0xFF.
- R2: Two consecutive writes of 0xA5 to the index port (0x2E) open the space (`cfg_open` = 1 from the next cycle). A single 0xA5 does not open it, and neither do key bytes written to any other address.
- R3: During the key sequence, a byte other than 0xA5 (and other than 0xAA) written to the index port restarts the sequence. Two further 0xA5 writes are then needed.
- R4: A write of 0xAA to the index port always closes the space from the next cycle: when open, halfway through the key sequence, or already closed.
- R5: While the space is closed, data port (0x2F) writes have no effect: no strobe, and no change to the device number or the scratch bytes. Reads of either port return 0xFF.
- R6: While the space is open, writing any byte other than 0xAA to the index port sets the index. Reading the index port returns it.
- R7: Index 0x07 is the logical device number. A data write stores the byte and a data read returns it.
- R8: For index ≥ 0x30, a data write drives `dev_wr` one-hot in the same cycle. The bit that goes high is the position of the device number in the device list {0x02,0x03,0x04,0x05,0x07,0x0B,0x0C,0x0D,0x0E} (bit 0 = 0x02). `dev_index` carries the index and `dev_wdata` carries the byte. A data read returns byte `dev_rdata[8*pos +: 8]` of that device.
- R9: If the device number is not in the list, bank writes raise no strobe and bank reads return 0xFF.
- R10: Scratch bytes at 0x28, 0x29 and 0x2D reset to 0x00. They can be written and read back whatever the device number is, and writing them raises no device strobe.
- R11: Any other index below 0x30 reads 0xFF, and writes to it raise no strobe.
- R12: Accesses to addresses other than the two ports change nothing and read 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte, combinational from `io_addr` |
| cfg_open | output | 1 | Configuration space is open |
| dev_wr | output | NDEV | One-hot bank write strobe |
| dev_index | output | 8 | Current index, towards the banks |
| dev_wdata | output | 8 | Write byte, towards the banks |
| dev_rdata | input | NDEV*8 | Read bytes from all banks, device 0 lowest |

## Verification
The bench walks the key sequence through its tricky paths. These are a lone key byte, a wrong byte after one key, a lock byte halfway through the sequence, and key bytes written to the wrong address. A design that keeps a partial key across an interruption would open too early. The bench sweeps the device number over 0x00 to 0x0F and one far value, and tries every bank index for each. This exposes a strobe on the wrong bank, a strobe for an unknown device, or a read-back from the wrong lane. A full read sweep of the index space catches scratch or unused indices that leak into bank decode. Writes made while the space is closed are then read back after reopening, which shows whether the closed state really blocked them.

// File: rtl/cfgp_pkg.sv
`timescale 1ns/1ps
package cfgp_pkg;
   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;

   localparam logic [7:0] IDLE_READ = 8'hFF;
endpackage

// File: rtl/cfgp_keylock.sv
`timescale 1ns/1ps
module cfgp_keylock
   import cfgp_pkg::*;
#(
   parameter logic [7:0] KEY_BYTE  = 8'hA5,
   parameter logic [7:0] LOCK_BYTE = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_wr,
   input  logic [7:0] key_data,
   output logic       open,
   output logic       index_load
);
   key_state_e st_q, st_d;

   always_comb begin
      st_d       = st_q;
      index_load = 1'b0;
      if (key_wr) begin
         if (key_data == LOCK_BYTE) begin
            st_d = KS_LOCKED;
         end else begin
            unique case (st_q)
               KS_LOCKED: st_d = (key_data == KEY_BYTE) ? KS_HALF : KS_LOCKED;
               KS_HALF:   st_d = (key_data == KEY_BYTE) ? KS_OPEN : KS_LOCKED;
               KS_OPEN:   index_load = 1'b1;
               default:   st_d = KS_LOCKED;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= KS_LOCKED;
      else        st_q <= st_d;
   end

   assign open = (st_q == KS_OPEN);
endmodule

// File: rtl/cfgp_scratch.sv
`timescale 1ns/1ps
module cfgp_scratch #(
   parameter int unsigned          NSCR     = 3,
   parameter logic [NSCR*8-1:0]    SCR_LIST = {8'h2D, 8'h29, 8'h28}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] index,
   input  logic [7:0] wdata,
   output logic       hit,
   output logic [7:0] rdata
);
   logic [NSCR-1:0]       sel;
   logic [NSCR-1:0][7:0]  lane;

   for (genvar g = 0; g < NSCR; g++) begin : g_byte
      logic [7:0] val_q;
      assign sel[g] = (index == SCR_LIST[g*8 +: 8]);
      always_ff @(posedge clk) begin
         if (!rst_n)                val_q <= 8'h00;
         else if (wr_en && sel[g])  val_q <= wdata;
      end
      assign lane[g] = sel[g] ? val_q : 8'h00;
   end

   always_comb begin
      rdata = 8'h00;
      for (int i = 0; i < NSCR; i++) rdata |= lane[i];
   end
   assign hit = |sel;
endmodule

// File: rtl/cfgp_devdec.sv
`timescale 1ns/1ps
module cfgp_devdec #(
   parameter int unsigned        NDEV     = 9,
   parameter logic [NDEV*8-1:0]  DEV_LIST = {8'h0E, 8'h0D, 8'h0C, 8'h0B,
                                             8'h07, 8'h05, 8'h04, 8'h03, 8'h02}
) (
   input  logic [7:0]         ldn,
   input  logic               wr_en,
   input  logic [NDEV*8-1:0]  bank_rdata,
   output logic [NDEV-1:0]    bank_wr,
   output logic               hit,
   output logic [7:0]         rdata
);
   logic [NDEV-1:0]       match;
   logic [NDEV-1:0][7:0]  lane;

   for (genvar g = 0; g < NDEV; g++) begin : g_dev
      for (genvar h = g + 1; h < NDEV; h++) begin : g_uniq
         if (DEV_LIST[g*8 +: 8] == DEV_LIST[h*8 +: 8]) begin : g_err
            $error("device list holds a duplicate number");
         end
      end
      assign match[g] = (ldn == DEV_LIST[g*8 +: 8]);
      assign lane[g]  = match[g] ? bank_rdata[g*8 +: 8] : 8'h00;
   end

   always_comb begin
      rdata = 8'h00;
      for (int i = 0; i < NDEV; i++) rdata |= lane[i];
   end
   assign bank_wr = wr_en ? match : '0;
   assign hit     = |match;
endmodule

// File: rtl/cfgp_index_port.sv
`timescale 1ns/1ps
module cfgp_index_port
   import cfgp_pkg::*;
#(
   parameter int unsigned          ADDR_W     = 16,
   parameter logic [ADDR_W-1:0]    INDEX_PORT = 'h2E,
   parameter logic [7:0]           KEY_BYTE   = 8'hA5,
   parameter logic [7:0]           LOCK_BYTE  = 8'hAA,
   parameter logic [7:0]           LDN_INDEX  = 8'h07,
   parameter logic [7:0]           BANK_BASE  = 8'h30,
   parameter int unsigned          NDEV       = 9,
   parameter logic [NDEV*8-1:0]    DEV_LIST   = {8'h0E, 8'h0D, 8'h0C, 8'h0B,
                                                 8'h07, 8'h05, 8'h04, 8'h03, 8'h02},
   parameter int unsigned          NSCR       = 3,
   parameter logic [NSCR*8-1:0]    SCR_LIST   = {8'h2D, 8'h29, 8'h28}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  io_addr,
   input  logic               io_wr,
   input  logic [7:0]         io_wdata,
   output logic [7:0]         io_rdata,
   output logic               cfg_open,
   output logic [NDEV-1:0]    dev_wr,
   output logic [7:0]         dev_index,
   output logic [7:0]         dev_wdata,
   input  logic [NDEV*8-1:0]  dev_rdata
);
   localparam logic [ADDR_W-1:0] DATA_PORT = INDEX_PORT + 1'b1;

   if (NDEV < 1) begin : g_chk_ndev
      $error("NDEV must be at least 1");
   end
   if (NSCR < 1) begin : g_chk_nscr
      $error("NSCR must be at least 1");
   end
   if (KEY_BYTE == LOCK_BYTE) begin : g_chk_key
      $error("key and lock bytes must differ");
   end
   if (INDEX_PORT == '1) begin : g_chk_port
      $error("data port would wrap past the address space");
   end
   for (genvar s = 0; s < NSCR; s++) begin : g_chk_scr
      if (SCR_LIST[s*8 +: 8] >= BANK_BASE || SCR_LIST[s*8 +: 8] == LDN_INDEX) begin : g_err
         $error("scratch index collides with another register");
      end
   end

   logic       idx_wr, dat_wr, dat_wr_open, idx_load;
   logic [7:0] index_q, ldn_q;
   logic       scr_hit, bank_hit;
   logic [7:0] scr_rdata, bank_rdata_sel;
   logic       in_bank;

   assign idx_wr      = io_wr && (io_addr == INDEX_PORT);
   assign dat_wr      = io_wr && (io_addr == DATA_PORT);
   assign dat_wr_open = dat_wr && cfg_open;
   assign in_bank     = (index_q >= BANK_BASE);

   cfgp_keylock #(.KEY_BYTE(KEY_BYTE), .LOCK_BYTE(LOCK_BYTE)) u_key (
      .clk        (clk),
      .rst_n      (rst_n),
      .key_wr     (idx_wr),
      .key_data   (io_wdata),
      .open       (cfg_open),
      .index_load (idx_load)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index_q <= 8'h00;
         ldn_q   <= 8'h00;
      end else begin
         if (idx_load) index_q <= io_wdata;
         if (dat_wr_open && index_q == LDN_INDEX) ldn_q <= io_wdata;
      end
   end

   cfgp_scratch #(.NSCR(NSCR), .SCR_LIST(SCR_LIST)) u_scr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (dat_wr_open),
      .index (index_q),
      .wdata (io_wdata),
      .hit   (scr_hit),
      .rdata (scr_rdata)
   );

   cfgp_devdec #(.NDEV(NDEV), .DEV_LIST(DEV_LIST)) u_dec (
      .ldn        (ldn_q),
      .wr_en      (dat_wr_open && in_bank),
      .bank_rdata (dev_rdata),
      .bank_wr    (dev_wr),
      .hit        (bank_hit),
      .rdata      (bank_rdata_sel)
   );

   assign dev_index = index_q;
   assign dev_wdata = io_wdata;

   always_comb begin
      io_rdata = IDLE_READ;
      if (cfg_open) begin
         if (io_addr == INDEX_PORT) begin
            io_rdata = index_q;
         end else if (io_addr == DATA_PORT) begin
            if (index_q == LDN_INDEX)        io_rdata = ldn_q;
            else if (scr_hit)                io_rdata = scr_rdata;
            else if (in_bank && bank_hit)    io_rdata = bank_rdata_sel;
         end
      end
   end
endmodule

// File: rtl/cfgp_index_port_chk.sv
`timescale 1ns/1ps
module cfgp_index_port_chk #(
   parameter int unsigned        ADDR_W     = 16,
   parameter logic [ADDR_W-1:0]  INDEX_PORT = 'h2E,
   parameter logic [7:0]         KEY_BYTE   = 8'hA5,
   parameter logic [7:0]         LOCK_BYTE  = 8'hAA,
   parameter int unsigned        NDEV       = 9
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  io_addr,
   input logic               io_wr,
   input logic [7:0]         io_wdata,
   input logic [7:0]         io_rdata,
   input logic               cfg_open,
   input logic [NDEV-1:0]    dev_wr
);
   localparam logic [ADDR_W-1:0] DPORT = INDEX_PORT + 1'b1;

   p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> $past(io_wr && io_addr == INDEX_PORT && io_wdata == KEY_BYTE));

   p_lock_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == INDEX_PORT && io_wdata == LOCK_BYTE) |=> !cfg_open);

   p_no_strobe_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |-> (dev_wr == '0));

   p_closed_reads_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && (io_addr == INDEX_PORT || io_addr == DPORT)) |-> (io_rdata == 8'hFF));

   p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_wr));

   p_strobe_from_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_wr != '0) |-> (io_wr && io_addr == DPORT));

   p_other_addr_ff_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr != INDEX_PORT && io_addr != DPORT) |-> (io_rdata == 8'hFF));
endmodule

bind cfgp_index_port cfgp_index_port_chk #(
   .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .KEY_BYTE(KEY_BYTE),
   .LOCK_BYTE(LOCK_BYTE), .NDEV(NDEV)
) u_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
   .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open), .dev_wr(dev_wr)
);

// File: tb/cfgp_index_port_test.sv
`timescale 1ns/1ps
module cfgp_index_port_test;
   localparam int NDEV = 9;
   localparam logic [7:0] DEVS [NDEV] = '{8'h02, 8'h03, 8'h04, 8'h05, 8'h07,
                                          8'h0B, 8'h0C, 8'h0D, 8'h0E};
   localparam logic [15:0] IP = 16'h002E, DP = 16'h002F;

   logic              clk = 1'b0, rst_n = 1'b0;
   logic [15:0]       io_addr = 16'h0;
   logic              io_wr = 1'b0;
   logic [7:0]        io_wdata = 8'h0, io_rdata;
   logic              cfg_open;
   logic [NDEV-1:0]   dev_wr;
   logic [7:0]        dev_index, dev_wdata;
   logic [NDEV*8-1:0] dev_rdata;
   int n_chk = 0, n_bad = 0;
   logic [NDEV-1:0]   s_wr;
   logic [7:0]        s_idx, s_wd, rd;
   logic [7:0]        scr [3];

   always #5 clk = ~clk;

   cfgp_index_port uut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
      .dev_wr(dev_wr), .dev_index(dev_index), .dev_wdata(dev_wdata),
      .dev_rdata(dev_rdata)
   );

   always_comb
      for (int i = 0; i < NDEV; i++)
         dev_rdata[i*8 +: 8] = dev_index ^ {DEVS[i][3:0], 4'h0};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wr = 1'b1; io_wdata = d;
      #2 s_wr = dev_wr; s_idx = dev_index; s_wd = dev_wdata;
      @(posedge clk);
      #1 io_wr = 1'b0;
   endtask

   task automatic get(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wr = 1'b0;
      #2 d = io_rdata;
   endtask

   function automatic int pos_of(input logic [7:0] n);
      for (int i = 0; i < NDEV; i++) if (DEVS[i] == n) return i;
      return -1;
   endfunction

   function automatic logic [7:0] bank_exp(input logic [7:0] n, input logic [7:0] idx);
      int p = pos_of(n);
      return (p < 0) ? 8'hFF : (idx ^ {DEVS[p][3:0], 4'h0});
   endfunction

   task automatic unlock();
      put(IP, 8'hA5); put(IP, 8'hA5);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk("R1 open", cfg_open, 0);
      get(IP, rd); chk("R1 index read", rd, 8'hFF);
      get(DP, rd); chk("R1 data read", rd, 8'hFF);
      chk("R1 strobe", dev_wr, 0);
      // R5 closed data write
      put(DP, 8'h55); chk("R5 closed strobe", s_wr, 0);
      // R12 key bytes at another address
      put(16'h0080, 8'hA5); put(16'h0080, 8'hA5); chk("R12 key elsewhere", cfg_open, 0);
      get(16'h0080, rd); chk("R12 other read", rd, 8'hFF);
      // R2 single key
      put(IP, 8'hA5); chk("R2 one key", cfg_open, 0);
      // R3 restart
      put(IP, 8'h12); put(IP, 8'hA5); chk("R3 restart", cfg_open, 0);
      put(IP, 8'hA5); chk("R2 two keys", cfg_open, 1);
      // R6 / R10
      put(IP, 8'h28); get(IP, rd); chk("R6 index read", rd, 8'h28);
      get(DP, rd); chk("R10 scratch reset", rd, 8'h00);
      // R7 device number
      put(IP, 8'h07); put(DP, 8'h3C); get(DP, rd); chk("R7 ldn", rd, 8'h3C);
      put(DP, 8'h0D);
      scr = '{8'h9C, 8'h41, 8'hE7};
      put(IP, 8'h28); put(DP, scr[0]); chk("R10 no strobe", s_wr, 0);
      put(IP, 8'h29); put(DP, scr[1]);
      put(IP, 8'h2D); put(DP, scr[2]);
      put(IP, 8'h07); put(DP, 8'h03);
      put(IP, 8'h28); get(DP, rd); chk("R10 28", rd, scr[0]);
      put(IP, 8'h29); get(DP, rd); chk("R10 29", rd, scr[1]);
      put(IP, 8'h2D); get(DP, rd); chk("R10 2D", rd, scr[2]);
      // R11 unused low index
      put(IP, 8'h10); put(DP, 8'h66); chk("R11 strobe", s_wr, 0);
      get(DP, rd); chk("R11 read", rd, 8'hFF);
      // R8 / R9 device sweep
      for (int n = 0; n < 17; n++) begin
         logic [7:0] ldn;
         logic [7:0] idxs [5];
         ldn = (n == 16) ? 8'h8D : 8'(n);
         idxs = '{8'h30, 8'h60, 8'h61, 8'h70, 8'h71};
         put(IP, 8'h07); put(DP, ldn);
         for (int k = 0; k < 5; k++) begin
            int p;
            logic [7:0] v;
            p = pos_of(ldn);
            v = 8'(n * 16 + k);
            put(IP, idxs[k]); put(DP, v);
            chk(p < 0 ? "R9 strobe" : "R8 strobe", s_wr, p < 0 ? 0 : (1 << p));
            if (p >= 0) begin
               chk("R8 index", s_idx, idxs[k]);
               chk("R8 wdata", s_wd, v);
            end
            get(DP, rd); chk(p < 0 ? "R9 read" : "R8 read", rd, bank_exp(ldn, idxs[k]));
         end
      end
      // R6 / R8 / R10 / R11 full index read sweep with device 0x05
      put(IP, 8'h07); put(DP, 8'h05);
      for (int i = 0; i < 256; i++) begin
         logic [7:0] ix, ex;
         ix = 8'(i);
         if (ix != 8'hAA) begin
            put(IP, ix);
            if (ix == 8'h07) ex = 8'h05;
            else if (ix == 8'h28) ex = scr[0];
            else if (ix == 8'h29) ex = scr[1];
            else if (ix == 8'h2D) ex = scr[2];
            else if (ix >= 8'h30) ex = bank_exp(8'h05, ix);
            else ex = 8'hFF;
            get(DP, rd); chk("R6 sweep", rd, ex);
         end
      end
      // R4 relock from open, then R5 closed writes ignored
      put(IP, 8'h28);
      put(IP, 8'hAA); chk("R4 relock open", cfg_open, 0);
      get(DP, rd); chk("R5 closed data read", rd, 8'hFF);
      get(IP, rd); chk("R5 closed index read", rd, 8'hFF);
      put(DP, 8'h77); chk("R5 closed strobe 2", s_wr, 0);
      put(IP, 8'hAA); chk("R4 relock closed", cfg_open, 0);
      unlock(); chk("R2 reopen", cfg_open, 1);
      put(IP, 8'h28); get(DP, rd); chk("R5 scratch kept", rd, scr[0]);
      put(IP, 8'hAA);
      // R4 lock byte halfway through the key
      put(IP, 8'hA5); put(IP, 8'hAA); put(IP, 8'hA5); chk("R4 half relock", cfg_open, 0);
      put(IP, 8'hA5); chk("R4 after half", cfg_open, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule